// File: doc/BRIEF.md
# Dual-FIFO Byte-Stream Port Register Block

This block is a bus-slave register file that couples a processor to a byte-stream side port through two deep byte queues. The processor pushes outgoing bytes into a transmit queue and pops incoming bytes from a receive queue through one data register. An agent on the side port drains the transmit queue and fills the receive queue. Serial shifting, parity and line framing are handled elsewhere. The block only stores the line configuration byte, the modem control byte and a 16-bit baud divisor (baud rate = 24 MHz / divisor) and drives them out to that logic.

The register window is 0x28 bytes, byte addressed on a 6-bit address. Offsets: 0x00 data (write = transmit push, read = receive pop), 0x04 line control on write and line status on read, 0x08 modem control, 0x0C divisor low byte (a read returns all 16 bits), 0x0D divisor high byte, 0x10 queue status, 0x14 transmit occupancy, 0x18 receive occupancy, 0x20 reset/enable, 0x24 side-port handshake byte. Other offsets read zero and ignore writes. Every read returns its data on `bus_rdata` in the cycle after `bus_rd` was sampled high. A side-port pop returns its byte on `side_tx_byte` with `side_tx_valid` high in the cycle after the pop was sampled.

Line status bits: bit7 receive pending, bit6 transmit queue empty, bit5 transmit done, bit2 receive overrun, all other bits zero. Queue status bits: bit0 transmit empty, bit1 transmit at or above one quarter, bit2 transmit full, bit3 transmit at or above three quarters, bit4 receive empty, bit5 receive at or above one quarter, bit6 receive full, bit7 receive at or above three quarters. Each queue holds 512 bytes.

Top module: `uart_dual_fifo_regs`

## Requirements
- R1: After reset, line status reads 0x40, queue status 0x11, modem control, divisor, both occupancy counts, reset/enable and handshake read 0x0000, and both queues are empty.
- R2: A data write with fewer than 512 bytes held enqueues the byte. A write with 512 bytes held is dropped. Side-port pops return the bytes in write order, and the transmit count at 0x14 tracks the number held. A pop of an empty queue returns with `side_tx_valid` low.
- R3: With modem control bit5 set, each side-port push enqueues its byte. Data reads return the bytes in push order, and the receive count at 0x18 tracks the number held.
- R4: The queue status flags follow the occupancy of each queue: the quarter flag at a count of 128 or more, the three-quarter flag at 384 or more, the full flag at 512, and the empty flag at 0.
- R5: A write of a nonzero byte to 0x0C or 0x0D loads the low or high divisor byte. A write of zero to either is ignored. The divisor reads back at 0x0C and drives `baud_div`. A write to 0x04 drives `line_ctrl` and does not change what 0x04 reads.
- R6: A write of exactly 0x55 to 0x20 flushes both queues and returns every register to its reset value. Any other value, 0xAA included, is stored and reads back at 0x20.
- R7: While modem control bit5 is clear, side-port pushes are discarded: the receive count and the line status do not change.
- R8: A data read that removes the last receive byte sets receive-empty, clears overrun (bit2) and receive pending (bit7), and loads the handshake byte with 0x0F.
- R9: A data read with the receive queue empty returns 0x00 and changes no count, flag or register.
- R10: The side-port pop that removes the last transmit byte sets line status bits 6 and 5 in the same cycle. The next accepted data write clears both.
- R11: A receive-enabled side push with 512 bytes held drops the byte and sets overrun (bit2).
- R12: Each accepted data write loads the handshake byte with 0xF0.
- R13: A push and a pop of the same non-empty, non-full queue in one cycle both take effect, and its count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (24 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset in the register window |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 16 | Read data, valid the cycle after the read |
| side_tx_pop | input | 1 | Side port takes one transmit byte |
| side_tx_byte | output | 8 | Popped transmit byte |
| side_tx_valid | output | 1 | High for one cycle when side_tx_byte holds a popped byte |
| side_rx_push | input | 1 | Side port offers one receive byte |
| side_rx_byte | input | 8 | Byte offered by the side port |
| line_ctrl | output | 8 | Stored line control byte |
| modem_ctrl | output | 8 | Stored modem control byte |
| baud_div | output | 16 | Baud divisor |

## Verification
The two activities that can fall in the same cycle are a processor access and a side-port access of the same queue. The bench raises a data write together with a side-port pop on a transmit queue that holds one byte, and a data read together with a side-port push on a partly filled receive queue. It judges each case by the byte that comes out, the unchanged occupancy count, and the absence of a transmit-done or receive-empty event. It also drives the full-queue boundary on both sides to show that the dropped byte never appears.

// File: rtl/udf_pkg.sv
package udf_pkg;

  localparam int BUS_AW = 6;
  localparam int BYTE_W = 8;
  localparam int RD_W   = 16;

  localparam logic [BUS_AW-1:0] OFF_DATA   = 6'h00;
  localparam logic [BUS_AW-1:0] OFF_LINE   = 6'h04;
  localparam logic [BUS_AW-1:0] OFF_MODEM  = 6'h08;
  localparam logic [BUS_AW-1:0] OFF_DIV_LO = 6'h0C;
  localparam logic [BUS_AW-1:0] OFF_DIV_HI = 6'h0D;
  localparam logic [BUS_AW-1:0] OFF_QSTAT  = 6'h10;
  localparam logic [BUS_AW-1:0] OFF_TXCNT  = 6'h14;
  localparam logic [BUS_AW-1:0] OFF_RXCNT  = 6'h18;
  localparam logic [BUS_AW-1:0] OFF_RSTEN  = 6'h20;
  localparam logic [BUS_AW-1:0] OFF_HSHAKE = 6'h24;

  localparam logic [BYTE_W-1:0] SOFT_RST_CODE  = 8'h55;
  localparam logic [BYTE_W-1:0] HS_RX_WRITABLE = 8'h0F;
  localparam logic [BYTE_W-1:0] HS_TX_READABLE = 8'hF0;

  localparam int MODEM_RX_EN_BIT = 5;

  // Occupancy flags of one queue, bit0 at the bottom.
  typedef struct packed {
    logic three_q;
    logic full;
    logic one_q;
    logic empty;
  } lvl_flags_t;

endpackage

// File: rtl/udf_byte_fifo.sv
module udf_byte_fifo #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          pop_done,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);

  // Storage and read port carry no reset so a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
    if (pop_ok)  pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      pop_done <= 1'b0;
    end else begin
      pop_done <= pop_ok;
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_PUSH_STEP: assert property (@(posedge clk) disable iff (clr) (push && !pop && count < CW'(DEPTH)) |=> count == $past(count) + 1'b1); // R2
  AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (clr) (push && !pop && count == CW'(DEPTH)) |=> count == CW'(DEPTH)); // R2
  AST_FIFO_BOTH_KEEP: assert property (@(posedge clk) disable iff (clr) (push && pop && count != '0 && count != CW'(DEPTH)) |=> $stable(count) && pop_done); // R13

endmodule

// File: rtl/udf_level_flags.sv
module udf_level_flags
  import udf_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int Q_MARK  = DEPTH / 4,
  localparam int TQ_MARK = (3 * DEPTH) / 4
) (
  input  logic [CW-1:0] count,
  output lvl_flags_t    flags
);

  always_comb begin
    flags.empty   = (count == '0);
    flags.one_q   = (count >= CW'(Q_MARK));
    flags.full    = (count == CW'(DEPTH));
    flags.three_q = (count >= CW'(TQ_MARK));
  end

endmodule

// File: rtl/udf_csr.sv
module udf_csr
  import udf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tx_accept,
  input  logic              tx_last_drain,
  input  logic              rx_side_push,
  input  logic              rx_overrun,
  input  logic              rx_drained,
  output logic [BYTE_W-1:0] line_q,
  output logic [BYTE_W-1:0] modem_q,
  output logic [2*BYTE_W-1:0] div_q,
  output logic [BYTE_W-1:0] rsten_q,
  output logic [BYTE_W-1:0] hs_q,
  output logic              rx_pend_q,
  output logic              ovr_q,
  output logic              tx_done_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q    <= '0;
      modem_q   <= '0;
      div_q     <= '0;
      rsten_q   <= '0;
      hs_q      <= '0;
      rx_pend_q <= 1'b0;
      ovr_q     <= 1'b0;
      tx_done_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          OFF_LINE:   line_q  <= wr_data;
          OFF_MODEM:  modem_q <= wr_data;
          OFF_DIV_LO: if (wr_data != '0) div_q[BYTE_W-1:0] <= wr_data;
          OFF_DIV_HI: if (wr_data != '0) div_q[2*BYTE_W-1:BYTE_W] <= wr_data;
          OFF_RSTEN:  rsten_q <= wr_data;
          default:    ;
        endcase
      end
      if (tx_accept) begin
        hs_q      <= HS_TX_READABLE;
        tx_done_q <= 1'b0;
      end
      if (tx_last_drain) tx_done_q <= 1'b1;
      if (rx_drained) begin
        hs_q      <= HS_RX_WRITABLE;
        ovr_q     <= 1'b0;
        rx_pend_q <= 1'b0;
      end
      if (rx_side_push) rx_pend_q <= 1'b1;
      if (rx_overrun)   ovr_q <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_dual_fifo_regs.sv
module uart_dual_fifo_regs
  import udf_pkg::*;
#(
  parameter int TX_DEPTH = 512,
  parameter int RX_DEPTH = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [RD_W-1:0]     bus_rdata,
  input  logic                side_tx_pop,
  output logic [BYTE_W-1:0]   side_tx_byte,
  output logic                side_tx_valid,
  input  logic                side_rx_push,
  input  logic [BYTE_W-1:0]   side_rx_byte,
  output logic [BYTE_W-1:0]   line_ctrl,
  output logic [BYTE_W-1:0]   modem_ctrl,
  output logic [2*BYTE_W-1:0] baud_div
);

  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);

  logic              soft_rst, blk_clr;
  logic              cpu_tx_wr, cpu_rx_rd, rx_push_en;
  logic              tx_accept, tx_last_drain, rx_overrun, rx_drained;
  logic [TX_CW-1:0]  tx_count;
  logic [RX_CW-1:0]  rx_count;
  logic [BYTE_W-1:0] rx_q;
  logic              rx_done;
  lvl_flags_t        tx_flags, rx_flags;
  logic [BYTE_W-1:0] rsten_q, hs_q, line_status, queue_status;
  logic              rx_pend_q, ovr_q, tx_done_q;
  logic [RD_W-1:0]   rd_mux, rdata_q;
  logic              sel_rx_q;

  // Bus decode and queue events.
  assign soft_rst   = bus_wr && (bus_addr == OFF_RSTEN) && (bus_wdata == SOFT_RST_CODE);
  assign blk_clr    = rst || soft_rst;
  assign cpu_tx_wr  = bus_wr && (bus_addr == OFF_DATA);
  assign cpu_rx_rd  = bus_rd && (bus_addr == OFF_DATA);
  assign rx_push_en = side_rx_push && modem_ctrl[MODEM_RX_EN_BIT];

  assign tx_accept     = cpu_tx_wr && (tx_count != TX_CW'(TX_DEPTH));
  assign tx_last_drain = side_tx_pop && (tx_count == TX_CW'(1)) && !tx_accept;
  assign rx_overrun    = rx_push_en && (rx_count == RX_CW'(RX_DEPTH));
  assign rx_drained    = cpu_rx_rd && (rx_count == RX_CW'(1)) && !rx_push_en;

  udf_byte_fifo #(.DEPTH(TX_DEPTH), .DW(BYTE_W)) u_tx_fifo (
    .clk(clk), .clr(blk_clr),
    .push(cpu_tx_wr), .push_data(bus_wdata),
    .pop(side_tx_pop), .pop_data(side_tx_byte), .pop_done(side_tx_valid),
    .count(tx_count)
  );

  udf_byte_fifo #(.DEPTH(RX_DEPTH), .DW(BYTE_W)) u_rx_fifo (
    .clk(clk), .clr(blk_clr),
    .push(rx_push_en), .push_data(side_rx_byte),
    .pop(cpu_rx_rd), .pop_data(rx_q), .pop_done(rx_done),
    .count(rx_count)
  );

  udf_level_flags #(.DEPTH(TX_DEPTH)) u_tx_lvl (.count(tx_count), .flags(tx_flags));
  udf_level_flags #(.DEPTH(RX_DEPTH)) u_rx_lvl (.count(rx_count), .flags(rx_flags));

  udf_csr u_csr (
    .clk(clk), .rst(blk_clr),
    .wr_en(bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .tx_accept(tx_accept), .tx_last_drain(tx_last_drain),
    .rx_side_push(rx_push_en), .rx_overrun(rx_overrun), .rx_drained(rx_drained),
    .line_q(line_ctrl), .modem_q(modem_ctrl), .div_q(baud_div),
    .rsten_q(rsten_q), .hs_q(hs_q),
    .rx_pend_q(rx_pend_q), .ovr_q(ovr_q), .tx_done_q(tx_done_q)
  );

  assign line_status  = {rx_pend_q, tx_flags.empty, tx_done_q, 2'b00, ovr_q, 2'b00};
  assign queue_status = {rx_flags, tx_flags};

  always_comb begin
    case (bus_addr)
      OFF_LINE:   rd_mux = RD_W'(line_status);
      OFF_MODEM:  rd_mux = RD_W'(modem_ctrl);
      OFF_DIV_LO: rd_mux = RD_W'(baud_div);
      OFF_DIV_HI: rd_mux = RD_W'(baud_div[2*BYTE_W-1:BYTE_W]);
      OFF_QSTAT:  rd_mux = RD_W'(queue_status);
      OFF_TXCNT:  rd_mux = RD_W'(tx_count);
      OFF_RXCNT:  rd_mux = RD_W'(rx_count);
      OFF_RSTEN:  rd_mux = RD_W'(rsten_q);
      OFF_HSHAKE: rd_mux = RD_W'(hs_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (blk_clr) begin
      rdata_q  <= '0;
      sel_rx_q <= 1'b0;
    end else if (bus_rd) begin
      rdata_q  <= rd_mux;
      sel_rx_q <= (bus_addr == OFF_DATA);
    end
  end

  assign bus_rdata = sel_rx_q ? RD_W'(rx_done ? rx_q : '0) : rdata_q;

  AST_SOFT_RST_FLUSH: assert property (@(posedge clk) disable iff (rst) soft_rst |=> (tx_count == '0) && (rx_count == '0) && (baud_div == '0)); // R6
  AST_DIV_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst) (bus_wr && bus_addr == OFF_DIV_LO && bus_wdata == '0) |=> $stable(baud_div)); // R5
  AST_RX_GATED: assert property (@(posedge clk) disable iff (rst) (side_rx_push && !modem_ctrl[MODEM_RX_EN_BIT] && !cpu_rx_rd && !soft_rst) |=> $stable(rx_count)); // R7
  AST_LAST_DRAIN: assert property (@(posedge clk) disable iff (rst) (tx_last_drain && !soft_rst) |=> line_status[6] && line_status[5]); // R10
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst) (cpu_rx_rd && rx_count == '0 && !side_rx_push && !soft_rst) |=> (bus_rdata == '0) && (rx_count == '0)); // R9
  AST_RX_DRAIN_HS: assert property (@(posedge clk) disable iff (rst) (rx_drained && !soft_rst) |=> (hs_q == HS_RX_WRITABLE) && !line_status[2] && queue_status[4]); // R8

endmodule

// File: tb/uart_dual_fifo_regs_tb.sv
module uart_dual_fifo_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  // {req[3:0], op[3:0] (1 = read and compare), addr[7:0], wdata[7:0], expected[15:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {4'd1, 4'd1, 8'h04, 8'h00, 16'h0040},
    {4'd1, 4'd1, 8'h10, 8'h00, 16'h0011},
    {4'd1, 4'd1, 8'h08, 8'h00, 16'h0000},
    {4'd1, 4'd1, 8'h0C, 8'h00, 16'h0000},
    {4'd1, 4'd1, 8'h14, 8'h00, 16'h0000},
    {4'd1, 4'd1, 8'h24, 8'h00, 16'h0000},
    {4'd5, 4'd0, 8'h0C, 8'h34, 16'h0000},
    {4'd5, 4'd0, 8'h0D, 8'h12, 16'h0000},
    {4'd5, 4'd1, 8'h0C, 8'h00, 16'h1234},
    {4'd5, 4'd0, 8'h0C, 8'h00, 16'h0000},
    {4'd5, 4'd0, 8'h0D, 8'h00, 16'h0000},
    {4'd5, 4'd1, 8'h0C, 8'h00, 16'h1234},
    {4'd5, 4'd1, 8'h0D, 8'h00, 16'h0012},
    {4'd6, 4'd0, 8'h20, 8'hAA, 16'h0000},
    {4'd6, 4'd1, 8'h20, 8'h00, 16'h00AA},
    {4'd6, 4'd0, 8'h20, 8'h3C, 16'h0000},
    {4'd6, 4'd1, 8'h20, 8'h00, 16'h003C}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        side_tx_pop = 1'b0;
  logic [7:0]  side_tx_byte;
  logic        side_tx_valid;
  logic        side_rx_push = 1'b0;
  logic [7:0]  side_rx_byte = '0;
  logic [7:0]  line_ctrl, modem_ctrl;
  logic [15:0] baud_div;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_dual_fifo_regs dut_i (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .side_tx_pop(side_tx_pop), .side_tx_byte(side_tx_byte), .side_tx_valid(side_tx_valid),
    .side_rx_push(side_rx_push), .side_rx_byte(side_rx_byte),
    .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .baud_div(baud_div)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bus_read(a, d);
    chk(tag, {16'h0, d}, {16'h0, exp});
  endtask

  task automatic side_push(input logic [7:0] d);
    side_rx_byte = d; side_rx_push = 1'b1;
    @(negedge clk);
    side_rx_push = 1'b0;
  endtask

  task automatic side_pop(output logic v, output logic [7:0] b);
    side_tx_pop = 1'b1;
    @(negedge clk);
    side_tx_pop = 1'b0;
    v = side_tx_valid; b = side_tx_byte;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("TIMEOUT watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic        v;
    logic [7:0]  b;
    logic [15:0] d;
    int          bad;

    repeat (3) @(negedge clk);
    chk("R1 tx_valid in reset", {31'h0, side_tx_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 baud_div after reset", {16'h0, baud_div}, 32'h0);

    // Table walk: reset values, divisor, reset/enable storage.
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][35:32] == 4'd1) begin
        bus_read(VEC[i][29:24], d);
        chk($sformatf("R%0d vector %0d", VEC[i][39:36], i), {16'h0, d}, {16'h0, VEC[i][15:0]});
      end else begin
        bus_write(VEC[i][29:24], VEC[i][23:16]);
      end
    end
    chk("R5 baud_div port", {16'h0, baud_div}, 32'h1234);

    // R5: line control drives its port; 0x04 still reads status.
    bus_write(6'h04, 8'h0B);
    chk("R5 line_ctrl port", {24'h0, line_ctrl}, 32'h0B);
    read_chk("R5 0x04 reads status", 6'h04, 16'h0040);

    // R6: soft reset flushes queues and registers.
    bus_write(6'h00, 8'h11);
    bus_write(6'h00, 8'h22);
    bus_write(6'h08, 8'h20);
    side_push(8'h33);
    read_chk("R6 tx count before flush", 6'h14, 16'd2);
    bus_write(6'h20, 8'h55);
    read_chk("R6 divisor cleared", 6'h0C, 16'h0000);
    read_chk("R6 tx count cleared", 6'h14, 16'h0000);
    read_chk("R6 rx count cleared", 6'h18, 16'h0000);
    read_chk("R6 reset/enable reads zero", 6'h20, 16'h0000);
    read_chk("R6 status reset value", 6'h04, 16'h0040);
    read_chk("R6 handshake cleared", 6'h24, 16'h0000);
    chk("R6 line_ctrl cleared", {24'h0, line_ctrl}, 32'h0);
    chk("R6 modem cleared", {24'h0, modem_ctrl}, 32'h0);

    // R7: receive disabled, pushes discarded.
    side_push(8'h12);
    read_chk("R7 rx count unchanged", 6'h18, 16'h0000);
    read_chk("R7 status unchanged", 6'h04, 16'h0040);

    // R9: empty read.
    read_chk("R9 empty read returns zero", 6'h00, 16'h0000);
    read_chk("R9 rx count stays zero", 6'h18, 16'h0000);
    read_chk("R9 queue status unchanged", 6'h10, 16'h0011);
    read_chk("R9 handshake unchanged", 6'h24, 16'h0000);

    // R2 / R4 / R12: fill the transmit queue.
    for (int i = 0; i < 512; i++) begin
      bus_write(6'h00, 8'(i));
      if (i == 0)   read_chk("R12 handshake after tx write", 6'h24, 16'h00F0);
      if (i == 126) read_chk("R4 tx at 127", 6'h10, 16'h0010);
      if (i == 127) read_chk("R4 tx at 128 quarter", 6'h10, 16'h0012);
      if (i == 383) read_chk("R4 tx at 384 three-quarter", 6'h10, 16'h001A);
    end
    read_chk("R4 tx full flags", 6'h10, 16'h001E);
    read_chk("R2 tx count full", 6'h14, 16'd512);
    bus_write(6'h00, 8'hEE);
    read_chk("R2 write to full dropped", 6'h14, 16'd512);
    read_chk("R10 status before drain", 6'h04, 16'h0000);
    bad = 0;
    for (int i = 0; i < 512; i++) begin
      side_pop(v, b);
      if (!v || b != 8'(i)) bad++;
    end
    chk("R2 drain order mismatches", bad, 0);
    read_chk("R10 last drain sets bits 6 and 5", 6'h04, 16'h0060);
    read_chk("R4 both empty after drain", 6'h10, 16'h0011);
    side_pop(v, b);
    chk("R2 pop of empty queue", {31'h0, v}, 32'h0);

    // R10: next accepted write clears done and empty.
    bus_write(6'h00, 8'hA1);
    read_chk("R10 write clears bits 6 and 5", 6'h04, 16'h0000);

    // R13: processor write and side pop in one cycle.
    bus_addr = 6'h00; bus_wdata = 8'hB2; bus_wr = 1'b1; side_tx_pop = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; side_tx_pop = 1'b0;
    chk("R13 concurrent pop byte", {23'h0, side_tx_valid, side_tx_byte}, {23'h0, 1'b1, 8'hA1});
    read_chk("R13 tx count unchanged", 6'h14, 16'd1);
    read_chk("R13 no done event", 6'h04, 16'h0000);
    side_pop(v, b);
    chk("R13 second byte", {23'h0, v, b}, {23'h0, 1'b1, 8'hB2});
    read_chk("R10 done after final drain", 6'h04, 16'h0060);

    // R3 / R4 / R11: fill the receive queue.
    bus_write(6'h20, 8'h55);
    bus_write(6'h08, 8'h20);
    for (int i = 0; i < 512; i++) begin
      side_push(8'(i) ^ 8'h5A);
      if (i == 127) read_chk("R4 rx at 128 quarter", 6'h10, 16'h0021);
    end
    read_chk("R4 rx full flags", 6'h10, 16'h00E1);
    read_chk("R3 rx count full", 6'h18, 16'd512);
    read_chk("R3 rx pending set", 6'h04, 16'h00C0);
    side_push(8'h99);
    read_chk("R11 overrun set", 6'h04, 16'h00C4);
    read_chk("R11 rx count held", 6'h18, 16'd512);
    read_chk("R3 first byte", 6'h00, 16'h005A);

    // R13: processor read and side push in one cycle.
    bus_addr = 6'h00; bus_rd = 1'b1; side_rx_byte = 8'h77; side_rx_push = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; side_rx_push = 1'b0;
    chk("R13 concurrent read byte", {16'h0, bus_rdata}, 32'h5B);
    read_chk("R13 rx count unchanged", 6'h18, 16'd511);

    bad = 0;
    for (int i = 2; i < 512; i++) begin
      bus_read(6'h00, d);
      if (d != {8'h00, 8'(i) ^ 8'h5A}) bad++;
    end
    chk("R3 receive order mismatches", bad, 0);
    read_chk("R3 rx count one left", 6'h18, 16'd1);
    read_chk("R3 last byte", 6'h00, 16'h0077);
    read_chk("R8 overrun and pending cleared", 6'h04, 16'h0040);
    read_chk("R8 handshake writable", 6'h24, 16'h000F);
    read_chk("R8 queue status empty", 6'h10, 16'h0011);
    read_chk("R9 empty read after drain", 6'h00, 16'h0000);
    read_chk("R9 handshake kept", 6'h24, 16'h000F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule